// File: doc/BRIEF.md
# Indexed Display Register Port

This block gives a host bus access to the control registers of a simple display adapter through two 32-bit ports. A write to the index port picks a register number. A later read or write on the value port then reaches the register that was picked. Behind the value port sit the version identifier, the enable and config-done flags, the pending mode width and height, the guest identifier and the cursor registers. It also holds a bank of scratch words that starts at a fixed index. Several read-only registers report fixed limits: the maximum mode size, the pixel depth, the capability bits and the command memory window.

Writes to the enable, config-done and sync registers each send a one-cycle strobe to the downstream blocks. A sync write also sets a busy bit, which the host can poll and which a downstream completion input clears. Value writes are checked before they are stored. The identifier takes only the three legal version codes. Mode sizes above the limits are dropped. The cursor-on register treats two of its codes as commands that leave the flag as it is. A read from an index that no register decodes returns zero and raises an error pulse.

Top module: `disp_regport`

## Requirements
- R1: Byte address 0 is the index port, byte address PORT_MUL is the value port and byte address 2*PORT_MUL is an auxiliary port. A read of the index port returns the last index written. An auxiliary read returns 0 and an auxiliary write does nothing. A read of any other address returns 32'hFFFFFFFF. Every read gives `bus_rvalid` high together with its data in the cycle after `bus_rd`, and `bus_rvalid` is low otherwise.
- R2: The identifier register (index 0) resets to 32'h9000_0002. A write to it is stored only if the value is 32'h9000_0000, 32'h9000_0001 or 32'h9000_0002, and any other value leaves it unchanged.
- R3: These indices read as constants: index 4 reads 2360 and index 5 reads 1770. Indices 7 and 28 read (DEPTH+7)&~7, which is 16 by default. Index 17 reads 32'h0000_00E3 (bit 0 rectangle fill, bit 1 rectangle copy, bit 5 cursor, bit 6 cursor bypass, bit 7 cursor bypass 2). Index 18 reads FIFO_BASE, index 19 reads FIFO_BYTES and index 29 reads SCRATCH_WORDS. A write to any of these indices, the depth register included, changes no read value.
- R4: A write to width (index 2) or height (index 3) is stored only when it is at most 2360 or 1770 respectively, and otherwise the old value stays. The stored values appear on `mode_width` and `mode_height`.
- R5: Index 12 reads the bytes per pixel ((DEPTH+7)&~7 divided by 8) times the stored width.
- R6: A write of 1 to cursor-on (index 27) sets `cursor_on` and a write of 0 clears it. Any other value leaves it unchanged. Indices 23, 24, 25 and 26 (guest, cursor id, cursor x, cursor y) read back the last 32-bit value written.
- R7: Indices from 1792 to 1792+SCRATCH_WORDS-1 read and write scratch word (index-1792). Index 1792+SCRATCH_WORDS reads 0.
- R8: A value-port read of an index that no register decodes (for example 6, 8, 30 or one past the scratch bank) returns 0 and pulses `bad_index` together with `bus_rvalid`. A write to such an index changes nothing.
- R9: A write to enable (index 1) or config-done (index 20) stores whether the value is nonzero (read back as 0 or 1, also driven on `enable_o` and `config_o`) and pulses `enable_stb` or `config_stb` for one cycle in the cycle after the write.
- R10: A write to sync (index 21) pulses `sync_stb` in the next cycle and sets busy (index 22 reads 1, index 21 reads 0). `sync_done` clears busy. When a sync write and `sync_done` fall in the same cycle, busy ends up set.
- R11: After reset the index is 0, enable, config-done, busy and cursor-on are 0, width and height are RST_WIDTH and RST_HEIGHT (640 and 480), the guest and cursor registers are 0, and no strobe, `bus_rvalid` or `bad_index` is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write request, one cycle per access |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| bad_index | output | 1 | Pulse: value read of an undecoded index |
| sync_done | input | 1 | Downstream signal that clears busy |
| enable_stb | output | 1 | Pulse after an enable write |
| config_stb | output | 1 | Pulse after a config-done write |
| sync_stb | output | 1 | Pulse after a sync write |
| enable_o | output | 1 | Stored enable flag |
| config_o | output | 1 | Stored config-done flag |
| cursor_on | output | 1 | Stored cursor visibility flag |
| mode_width | output | DIM_W | Pending mode width |
| mode_height | output | DIM_W | Pending mode height |

## Verification
The busy bit has two causes that can meet in one cycle: a host sync write sets it while the downstream `sync_done` input clears it. The bench drives both in the same clock, then reads index 22 and expects 1, because the new sync wins. It then sends a lone `sync_done` and expects 0. A behavioural model updates busy with the same set-over-clear rule and compares the read data and `sync_stb` on every clock.

// File: rtl/disp_regport_pkg.sv
package disp_regport_pkg;

  localparam logic [31:0] VER_MAGIC    = 32'h9000_0000;
  localparam logic [31:0] VER_ID0      = VER_MAGIC | 32'd0;
  localparam logic [31:0] VER_ID1      = VER_MAGIC | 32'd1;
  localparam logic [31:0] VER_ID2      = VER_MAGIC | 32'd2;

  localparam logic [31:0] IX_ID        = 32'd0;
  localparam logic [31:0] IX_ENABLE    = 32'd1;
  localparam logic [31:0] IX_WIDTH     = 32'd2;
  localparam logic [31:0] IX_HEIGHT    = 32'd3;
  localparam logic [31:0] IX_MAXW      = 32'd4;
  localparam logic [31:0] IX_MAXH      = 32'd5;
  localparam logic [31:0] IX_DEPTH     = 32'd7;
  localparam logic [31:0] IX_PITCH     = 32'd12;
  localparam logic [31:0] IX_CAPS      = 32'd17;
  localparam logic [31:0] IX_FIFO_BASE = 32'd18;
  localparam logic [31:0] IX_FIFO_LEN  = 32'd19;
  localparam logic [31:0] IX_CFG_DONE  = 32'd20;
  localparam logic [31:0] IX_SYNC      = 32'd21;
  localparam logic [31:0] IX_BUSY      = 32'd22;
  localparam logic [31:0] IX_GUEST     = 32'd23;
  localparam logic [31:0] IX_CUR_ID    = 32'd24;
  localparam logic [31:0] IX_CUR_X     = 32'd25;
  localparam logic [31:0] IX_CUR_Y     = 32'd26;
  localparam logic [31:0] IX_CUR_ON    = 32'd27;
  localparam logic [31:0] IX_HOST_DEP  = 32'd28;
  localparam logic [31:0] IX_SCR_SIZE  = 32'd29;
  localparam logic [31:0] IX_SCR_BASE  = 32'd1792;

  localparam logic [31:0] CUR_HIDE     = 32'd0;
  localparam logic [31:0] CUR_SHOW     = 32'd1;

  function automatic logic ver_legal(input logic [31:0] v);
    return (v == VER_ID0) || (v == VER_ID1) || (v == VER_ID2);
  endfunction

endpackage

// File: rtl/disp_addr_decode.sv
module disp_addr_decode #(
  parameter int ADDR_W   = 4,
  parameter int PORT_MUL = 1
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              val_wr,
  output logic              val_rd,
  output logic              aux_rd,
  output logic              none_rd
);
  localparam logic [ADDR_W-1:0] A_IDX = '0;
  localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(PORT_MUL);
  localparam logic [ADDR_W-1:0] A_AUX = ADDR_W'(2 * PORT_MUL);

  logic hit_idx, hit_val, hit_aux;

  always_comb begin
    hit_idx = (bus_addr == A_IDX);
    hit_val = (bus_addr == A_VAL);
    hit_aux = (bus_addr == A_AUX);
    idx_wr  = bus_wr && hit_idx;
    idx_rd  = bus_rd && hit_idx;
    val_wr  = bus_wr && hit_val;
    val_rd  = bus_rd && hit_val;
    aux_rd  = bus_rd && hit_aux;
    none_rd = bus_rd && !(hit_idx || hit_val || hit_aux);
  end
endmodule

// File: rtl/disp_scratch_ram.sv
module disp_scratch_ram #(
  parameter int WORDS = 256,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/disp_ctrl_regs.sv
module disp_ctrl_regs
  import disp_regport_pkg::*;
#(
  parameter int          DIM_W      = 12,
  parameter int          MAX_W      = 2360,
  parameter int          MAX_H      = 1770,
  parameter int          RST_WIDTH  = 640,
  parameter int          RST_HEIGHT = 480,
  parameter int          DEPTH      = 15,
  parameter logic [31:0] CAPS       = 32'h0000_00E3,
  parameter logic [31:0] FIFO_BASE  = 32'hE000_0000,
  parameter logic [31:0] FIFO_BYTES = 32'h0001_0000,
  parameter int          SCR_WORDS  = 256,
  parameter int          SAW        = $clog2(SCR_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_wr,
  input  logic             idx_rd,
  input  logic             val_wr,
  input  logic             val_rd,
  input  logic             aux_rd,
  input  logic             none_rd,
  input  logic [31:0]      wdata,
  input  logic             sync_done,
  output logic [31:0]      cur_index,
  output logic [31:0]      ctl_rdata,
  output logic             scr_sel_q,
  output logic             rvalid,
  output logic             bad_q,
  output logic             scr_en,
  output logic             scr_we,
  output logic [SAW-1:0]   scr_addr,
  output logic             enable_stb,
  output logic             config_stb,
  output logic             sync_stb,
  output logic             enable_q,
  output logic             config_q,
  output logic             cursor_on_q,
  output logic [DIM_W-1:0] width_q,
  output logic [DIM_W-1:0] height_q
);
  localparam logic [31:0] BPP_RD  = 32'(((DEPTH + 7) / 8) * 8);
  localparam logic [31:0] BYPP    = BPP_RD / 32'd8;
  localparam logic [31:0] SCR_END = IX_SCR_BASE + 32'(SCR_WORDS);

  logic [31:0] id_q, guest_q, cur_id_q, cur_x_q, cur_y_q;
  logic        busy_q;
  logic        in_scr;
  logic [31:0] rd_val;
  logic        rd_known;

  assign in_scr   = (cur_index >= IX_SCR_BASE) && (cur_index < SCR_END);
  assign scr_addr = SAW'(cur_index - IX_SCR_BASE);
  assign scr_en   = in_scr && (val_rd || val_wr);
  assign scr_we   = in_scr && val_wr;

  always_comb begin
    rd_known = 1'b1;
    rd_val   = '0;
    case (cur_index)
      IX_ID:        rd_val = id_q;
      IX_ENABLE:    rd_val = {31'd0, enable_q};
      IX_WIDTH:     rd_val = 32'(width_q);
      IX_HEIGHT:    rd_val = 32'(height_q);
      IX_MAXW:      rd_val = 32'(MAX_W);
      IX_MAXH:      rd_val = 32'(MAX_H);
      IX_DEPTH,
      IX_HOST_DEP:  rd_val = BPP_RD;
      IX_PITCH:     rd_val = BYPP * 32'(width_q);
      IX_CAPS:      rd_val = CAPS;
      IX_FIFO_BASE: rd_val = FIFO_BASE;
      IX_FIFO_LEN:  rd_val = FIFO_BYTES;
      IX_CFG_DONE:  rd_val = {31'd0, config_q};
      IX_SYNC:      rd_val = '0;
      IX_BUSY:      rd_val = {31'd0, busy_q};
      IX_GUEST:     rd_val = guest_q;
      IX_CUR_ID:    rd_val = cur_id_q;
      IX_CUR_X:     rd_val = cur_x_q;
      IX_CUR_Y:     rd_val = cur_y_q;
      IX_CUR_ON:    rd_val = {31'd0, cursor_on_q};
      IX_SCR_SIZE:  rd_val = 32'(SCR_WORDS);
      default:      rd_known = 1'b0;
    endcase
  end

  // read path: one register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_rdata <= '0;
      scr_sel_q <= 1'b0;
      rvalid    <= 1'b0;
      bad_q     <= 1'b0;
    end else begin
      rvalid    <= idx_rd || val_rd || aux_rd || none_rd;
      scr_sel_q <= val_rd && in_scr;
      bad_q     <= val_rd && !in_scr && !rd_known;
      if (idx_rd)       ctl_rdata <= cur_index;
      else if (val_rd)  ctl_rdata <= rd_known ? rd_val : 32'd0;
      else if (aux_rd)  ctl_rdata <= '0;
      else if (none_rd) ctl_rdata <= '1;
    end
  end

  // write path
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_index   <= '0;
      id_q        <= VER_ID2;
      enable_q    <= 1'b0;
      config_q    <= 1'b0;
      width_q     <= DIM_W'(RST_WIDTH);
      height_q    <= DIM_W'(RST_HEIGHT);
      guest_q     <= '0;
      cur_id_q    <= '0;
      cur_x_q     <= '0;
      cur_y_q     <= '0;
      cursor_on_q <= 1'b0;
      busy_q      <= 1'b0;
      enable_stb  <= 1'b0;
      config_stb  <= 1'b0;
      sync_stb    <= 1'b0;
    end else begin
      enable_stb <= 1'b0;
      config_stb <= 1'b0;
      sync_stb   <= 1'b0;
      if (idx_wr) cur_index <= wdata;
      if (val_wr && cur_index == IX_SYNC) busy_q <= 1'b1;
      else if (sync_done)                 busy_q <= 1'b0;
      if (val_wr) begin
        case (cur_index)
          IX_ID:       if (ver_legal(wdata)) id_q <= wdata;
          IX_ENABLE:   begin enable_q <= |wdata; enable_stb <= 1'b1; end
          IX_WIDTH:    if (wdata <= 32'(MAX_W)) width_q <= DIM_W'(wdata);
          IX_HEIGHT:   if (wdata <= 32'(MAX_H)) height_q <= DIM_W'(wdata);
          IX_CFG_DONE: begin config_q <= |wdata; config_stb <= 1'b1; end
          IX_SYNC:     sync_stb <= 1'b1;
          IX_GUEST:    guest_q <= wdata;
          IX_CUR_ID:   cur_id_q <= wdata;
          IX_CUR_X:    cur_x_q <= wdata;
          IX_CUR_Y:    cur_y_q <= wdata;
          IX_CUR_ON: begin
            if (wdata == CUR_SHOW)      cursor_on_q <= 1'b1;
            else if (wdata == CUR_HIDE) cursor_on_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/disp_regport.sv
module disp_regport #(
  parameter int          ADDR_W     = 4,
  parameter int          PORT_MUL   = 1,
  parameter int          DIM_W      = 12,
  parameter int          MAX_W      = 2360,
  parameter int          MAX_H      = 1770,
  parameter int          RST_WIDTH  = 640,
  parameter int          RST_HEIGHT = 480,
  parameter int          DEPTH      = 15,
  parameter logic [31:0] CAPS       = 32'h0000_00E3,
  parameter logic [31:0] FIFO_BASE  = 32'hE000_0000,
  parameter logic [31:0] FIFO_BYTES = 32'h0001_0000,
  parameter int          SCR_WORDS  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bad_index,
  input  logic              sync_done,
  output logic              enable_stb,
  output logic              config_stb,
  output logic              sync_stb,
  output logic              enable_o,
  output logic              config_o,
  output logic              cursor_on,
  output logic [DIM_W-1:0]  mode_width,
  output logic [DIM_W-1:0]  mode_height
);
  localparam int SAW = $clog2(SCR_WORDS);

  logic           idx_wr, idx_rd, val_wr, val_rd, aux_rd, none_rd;
  logic [31:0]    cur_index, ctl_rdata, scr_rdata;
  logic           scr_sel_q, scr_en, scr_we;
  logic [SAW-1:0] scr_addr;

  disp_addr_decode #(.ADDR_W(ADDR_W), .PORT_MUL(PORT_MUL)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .idx_wr(idx_wr), .idx_rd(idx_rd), .val_wr(val_wr), .val_rd(val_rd),
    .aux_rd(aux_rd), .none_rd(none_rd)
  );

  disp_ctrl_regs #(
    .DIM_W(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H),
    .RST_WIDTH(RST_WIDTH), .RST_HEIGHT(RST_HEIGHT), .DEPTH(DEPTH),
    .CAPS(CAPS), .FIFO_BASE(FIFO_BASE), .FIFO_BYTES(FIFO_BYTES),
    .SCR_WORDS(SCR_WORDS), .SAW(SAW)
  ) u_regs (
    .clk(clk), .rst(rst),
    .idx_wr(idx_wr), .idx_rd(idx_rd), .val_wr(val_wr), .val_rd(val_rd),
    .aux_rd(aux_rd), .none_rd(none_rd), .wdata(bus_wdata),
    .sync_done(sync_done), .cur_index(cur_index), .ctl_rdata(ctl_rdata),
    .scr_sel_q(scr_sel_q), .rvalid(bus_rvalid), .bad_q(bad_index),
    .scr_en(scr_en), .scr_we(scr_we), .scr_addr(scr_addr),
    .enable_stb(enable_stb), .config_stb(config_stb), .sync_stb(sync_stb),
    .enable_q(enable_o), .config_q(config_o), .cursor_on_q(cursor_on),
    .width_q(mode_width), .height_q(mode_height)
  );

  disp_scratch_ram #(.WORDS(SCR_WORDS), .AW(SAW)) u_scr (
    .clk(clk), .en(scr_en), .we(scr_we), .addr(scr_addr),
    .wdata(bus_wdata), .rdata(scr_rdata)
  );

  assign bus_rdata = scr_sel_q ? scr_rdata : ctl_rdata;
endmodule

// File: rtl/disp_regport_chk.sv
module disp_regport_chk #(
  parameter int DIM_W = 12,
  parameter int MAX_W = 2360,
  parameter int MAX_H = 1770
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic             bus_rvalid,
  input logic             bad_index,
  input logic             val_wr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      cur_index,
  input logic             enable_stb,
  input logic             sync_stb,
  input logic             cursor_on,
  input logic [DIM_W-1:0] mode_width,
  input logic [DIM_W-1:0] mode_height
);
  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R1
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid); // R1
  AST_WIDTH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(mode_width) <= 32'(MAX_W)); // R4
  AST_HEIGHT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(mode_height) <= 32'(MAX_H)); // R4
  AST_CURSOR_SHOW: assert property (@(posedge clk) disable iff (rst)
    $past(val_wr && cur_index == 32'd27 && bus_wdata == 32'd1) |-> cursor_on); // R6
  AST_CURSOR_KEEP: assert property (@(posedge clk) disable iff (rst)
    $past(val_wr && cur_index == 32'd27 && bus_wdata > 32'd1) |-> $stable(cursor_on)); // R6
  AST_BAD_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    bad_index |-> bus_rvalid); // R8
  AST_ENABLE_STB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    enable_stb |-> $past(val_wr && cur_index == 32'd1)); // R9
  AST_SYNC_STB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $past(val_wr && cur_index == 32'd21) |-> sync_stb); // R10
endmodule

bind disp_regport disp_regport_chk #(.DIM_W(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .bad_index(bad_index), .val_wr(val_wr), .bus_wdata(bus_wdata),
  .cur_index(cur_index), .enable_stb(enable_stb), .sync_stb(sync_stb),
  .cursor_on(cursor_on), .mode_width(mode_width), .mode_height(mode_height)
);

// File: tb/disp_regport_bench.sv
module disp_regport_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SCRW = 256;
  localparam logic [31:0] FBASE = 32'hE000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, sync_done = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bad_index, enable_stb, config_stb, sync_stb;
  logic        enable_o, config_o, cursor_on;
  logic [11:0] mode_width, mode_height;

  always #2.5 clk = ~clk;

  disp_regport u_disp_regport (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .bad_index(bad_index), .sync_done(sync_done), .enable_stb(enable_stb),
    .config_stb(config_stb), .sync_stb(sync_stb), .enable_o(enable_o),
    .config_o(config_o), .cursor_on(cursor_on), .mode_width(mode_width),
    .mode_height(mode_height)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R11";
  bit    done = 1'b0;

  // behavioural reference model
  logic [31:0] m_index, m_id, m_w, m_h, m_guest, m_cid, m_cx, m_cy;
  bit          m_en, m_cfg, m_on, m_busy;
  logic [31:0] scr [int unsigned];
  bit          e_rv, e_bad, e_en_stb, e_cfg_stb, e_sync_stb;
  logic [31:0] e_rd;

  function automatic logic [31:0] model_read(output bit known);
    logic [31:0] i = m_index;
    known = 1'b1;
    if (i >= 32'd1792 && i < 32'd1792 + SCRW)
      return scr.exists(i) ? scr[i] : 32'd0;
    case (i)
      0: return m_id;        1: return {31'd0, m_en};
      2: return m_w;         3: return m_h;
      4: return 32'd2360;    5: return 32'd1770;
      7, 28: return 32'd16;  12: return 32'd2 * m_w;
      17: return 32'hE3;     18: return FBASE;
      19: return 32'h10000;  20: return {31'd0, m_cfg};
      21: return 32'd0;      22: return {31'd0, m_busy};
      23: return m_guest;    24: return m_cid;
      25: return m_cx;       26: return m_cy;
      27: return {31'd0, m_on};
      29: return SCRW;
      default: begin known = 1'b0; return 32'd0; end
    endcase
  endfunction

  always @(posedge clk) begin
    bit k;
    if (rst) begin
      m_index = 0; m_id = 32'h9000_0002; m_w = 640; m_h = 480;
      m_guest = 0; m_cid = 0; m_cx = 0; m_cy = 0;
      m_en = 0; m_cfg = 0; m_on = 0; m_busy = 0;
      e_rv = 0; e_bad = 0; e_en_stb = 0; e_cfg_stb = 0; e_sync_stb = 0; e_rd = 0;
    end else begin
      e_rv = bus_rd; e_bad = 0;
      e_en_stb = 0; e_cfg_stb = 0; e_sync_stb = 0;
      if (bus_rd) begin
        if (bus_addr == 0) e_rd = m_index;
        else if (bus_addr == 1) begin e_rd = model_read(k); e_bad = !k; end
        else if (bus_addr == 2) e_rd = 0;
        else e_rd = 32'hFFFF_FFFF;
      end
      if (bus_wr && bus_addr == 1 && m_index == 21) m_busy = 1;
      else if (sync_done) m_busy = 0;
      if (bus_wr && bus_addr == 0) m_index = bus_wdata;
      else if (bus_wr && bus_addr == 1) begin
        if (m_index >= 32'd1792 && m_index < 32'd1792 + SCRW) scr[m_index] = bus_wdata;
        case (m_index)
          0: if (bus_wdata inside {32'h9000_0000, 32'h9000_0001, 32'h9000_0002}) m_id = bus_wdata;
          1: begin m_en = bus_wdata != 0; e_en_stb = 1; end
          2: if (bus_wdata <= 2360) m_w = bus_wdata;
          3: if (bus_wdata <= 1770) m_h = bus_wdata;
          20: begin m_cfg = bus_wdata != 0; e_cfg_stb = 1; end
          21: e_sync_stb = 1;
          23: m_guest = bus_wdata;
          24: m_cid = bus_wdata;
          25: m_cx = bus_wdata;
          26: m_cy = bus_wdata;
          27: if (bus_wdata == 1) m_on = 1; else if (bus_wdata == 0) m_on = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(bus_rvalid == e_rv, "R1", "rvalid", 32'(bus_rvalid), 32'(e_rv));
      if (e_rv) check(bus_rdata == e_rd, cur_req, "rdata", bus_rdata, e_rd);
      check(bad_index == e_bad, "R8", "bad_index", 32'(bad_index), 32'(e_bad));
      check(enable_stb == e_en_stb, "R9", "enable_stb", 32'(enable_stb), 32'(e_en_stb));
      check(config_stb == e_cfg_stb, "R9", "config_stb", 32'(config_stb), 32'(e_cfg_stb));
      check(sync_stb == e_sync_stb, "R10", "sync_stb", 32'(sync_stb), 32'(e_sync_stb));
      check(enable_o == m_en && config_o == m_cfg, "R9", "flags",
            {30'd0, enable_o, config_o}, {30'd0, m_en, m_cfg});
      check(32'(mode_width) == m_w, "R4", "mode_width", 32'(mode_width), m_w);
      check(32'(mode_height) == m_h, "R4", "mode_height", 32'(mode_height), m_h);
      check(cursor_on == m_on, "R6", "cursor_on", 32'(cursor_on), 32'(m_on));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(input logic [3:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask
  task automatic wv(input logic [31:0] i, input logic [31:0] d);
    wr(0, i); wr(1, d);
  endtask
  task automatic rv(input logic [31:0] i);
    wr(0, i); rd(1); @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R11";
    for (int i = 0; i < 30; i++) rv(i);
    cur_req = "R1";
    wr(0, 32'h0000_1234); rd(0); rd(2); wr(2, 32'h55); rd(5); rd(15); rd(3);
    cur_req = "R2";
    wv(0, 32'h9000_0000); rv(0); wv(0, 32'h0001_2345); rv(0);
    wv(0, 32'h9000_0003); rv(0); wv(0, 32'h9000_0001); rv(0);
    cur_req = "R3";
    foreach (scr[k]) ;
    wv(4, 99); wv(5, 99); wv(7, 32); wv(17, 0); wv(18, 1); wv(19, 1); wv(29, 1); wv(28, 8);
    for (int i = 4; i < 30; i++) if (i inside {4, 5, 7, 17, 18, 19, 28, 29}) rv(i);
    cur_req = "R4";
    wv(2, 2360); rv(2); wv(2, 2361); rv(2); wv(3, 1771); rv(3); wv(3, 1770); rv(3);
    wv(2, 32'h8000_0005); rv(2); wv(2, 800); wv(3, 0); rv(3);
    cur_req = "R5";
    rv(12); wv(2, 0); rv(12); wv(2, 1023); rv(12);
    cur_req = "R6";
    wv(27, 1); wv(27, 2); rv(27); wv(27, 3); wv(27, 0); rv(27); wv(27, 3);
    wv(27, 1); wv(27, 7); rv(27); wv(27, 0);
    wv(23, 32'h5001); wv(24, 9); wv(25, 320); wv(26, 200);
    rv(23); rv(24); rv(25); rv(26);
    cur_req = "R7";
    wv(1792, 32'hCAFE_0001); wv(1792 + SCRW - 1, 32'hBEEF_00FF);
    wv(1800, 32'h1357_9BDF); wv(1792 + SCRW, 32'hDEAD_DEAD);
    rv(1792); rv(1792 + SCRW - 1); rv(1800); rv(1801); rv(1792 + SCRW);
    wv(1800, 32'h0246_8ACE); rv(1800);
    cur_req = "R8";
    rv(6); rv(8); rv(30); rv(1791); rv(32'hFFFF_FFFF); wv(8, 5); rv(8);
    cur_req = "R9";
    wv(1, 5); rv(1); wv(1, 0); rv(1); wv(20, 32'h8000_0000); rv(20); wv(20, 0); rv(20);
    wv(1, 1); wv(20, 1);
    cur_req = "R10";
    wv(21, 0); rv(22); rv(21);
    sync_done = 1'b1; @(negedge clk); sync_done = 1'b0; rv(22);
    wr(0, 21);
    bus_addr = 1; bus_wdata = 0; bus_wr = 1'b1; sync_done = 1'b1;
    @(negedge clk); bus_wr = 1'b0; sync_done = 1'b0;
    rv(22);
    sync_done = 1'b1; @(negedge clk); sync_done = 1'b0; rv(22);
    cur_req = "R11";
    rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0; @(negedge clk);
    rd(0); rv(1); rv(2); rv(22); rv(27); rv(1792);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule